// File: doc/BRIEF.md
# Host-Clocked Converter Serial Port with Data-Ready Flag

This block is the serial interface of a converter for the case where the host drives the serial clock. Over one data line in each direction, the host reaches three registers: an output register that holds the latest conversion word, a 24-bit control register and a 24-bit calibration register. The output register is read in 16-bit or 24-bit form. It uses an active-low read frame, an active-low write frame and a register select. Conversion words arrive from outside on a single-cycle valid pulse.

An active-low data-ready flag marks an unread conversion word. The flag is cleared only when the last bit of that word has been read out. Either frame may be raised in the middle of a word and lowered again later, and the transfer then continues from the same bit position. The serial clock, the two frames, the select and the serial input are resynchronised into the system clock. The system clock must be several times faster than the serial clock. The serial output comes with an enable for an external tristate driver.

Top module: `ext_serial_port`

## Requirements
- R1: After reset, `drdy_no` is high, `sdata_oe_o` is low, and `ctrl_o` and `cal_o` are zero.
- R2: A pulse on `conv_valid_i` outside an output read loads `conv_data_i` and drives `drdy_no` low. If several words arrive before a read, the read returns the newest one.
- R3: An output read shifts out 24 bits when control bit 0 is 0. It shifts out 16 bits, namely word bits 23:8, when control bit 0 is 1. `drdy_no` stays low until the serial clock falls after the last bit, and goes high then.
- R4: When `reg_sel_i` is high and control bit 1 is 0, a read frame that falls while `drdy_no` is high starts no transfer. The output stays disabled, and no bit position advances.
- R5: The first bit of a read is the most significant bit, driven as soon as the frame is low. Each later bit appears after a falling serial clock edge. The output enable is high only while a word is in progress and the read frame is low. It drops after the fall that follows the last bit.
- R6: If the read frame rises in the middle of a word, the output is disabled and the bit position is kept. When the frame falls again, the read continues with the next bit.
- R7: A conversion word that arrives while an output read is in progress is discarded. `drdy_no` shows no sign of it.
- R8: With `reg_sel_i` low, a read returns the control register. With `reg_sel_i` high and control bit 1 set, a read returns the calibration register. Both reads are 24 bits, do not depend on `drdy_no` and do not change it.
- R9: A write shifts in 24 bits, most significant bit first, each one sampled on a rising serial clock edge while the write frame is low. Clock edges seen while the write frame is high are ignored. The completed word goes to the control register when `reg_sel_i` is low and to the calibration register when it is high. Writes leave `drdy_no` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| rd_frame_ni | input | 1 | Read frame, active low |
| wr_frame_ni | input | 1 | Write frame, active low |
| reg_sel_i | input | 1 | Register select: 0 = control, 1 = output or calibration |
| sdata_i | input | 1 | Serial write data |
| conv_valid_i | input | 1 | One-cycle pulse marking a new conversion word |
| conv_data_i | input | DATA_W | New conversion word |
| sdata_o | output | 1 | Serial read data |
| sdata_oe_o | output | 1 | Enable for the serial output driver |
| drdy_no | output | 1 | Data-ready flag, low while an unread word is held |
| ctrl_o | output | DATA_W | Control register contents |
| cal_o | output | DATA_W | Calibration register contents |

## Verification
Output reads are tested with a split at every bit position from 1 to 23 as well as unsplit, using 24 distinct arithmetic words. This separates errors in bit-position retention from errors in shifting order. Short-mode reads with splits confirm that the upper 16 bits are selected and that the flag clears at bit 16 rather than bit 24. Further patterns cover two words back to back, a word arriving in the middle of a read, a read frame with no data ready, and control and calibration reads taken with the flag in both states. These tell apart newest-wins from dropped-during-read and show that the flag is independent of register reads. Writes use a walking one with a pause at each position, during which the data line is inverted and a clock pulse is sent. This exposes both misordered bits and clock edges wrongly taken while the frame is high.

// File: rtl/esp_pkg.sv
`timescale 1ns/1ps
package esp_pkg;
  typedef enum logic [1:0] {
    SRC_OUT  = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_CAL  = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic sel;
    logic sdata;
    logic wr_n;
    logic rd_n;
    logic sclk;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);
  localparam logic [PINS_W-1:0] PINS_IDLE = 5'b00110;
endpackage

// File: rtl/esp_sync.sv
`timescale 1ns/1ps
module esp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/esp_rd_path.sv
`timescale 1ns/1ps
module esp_rd_path
  import esp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              frame_low_i,
  input  logic              sclk_fall_i,
  input  logic              sel_i,
  input  logic              cal_sel_i,
  input  logic              short_i,
  input  logic              drdy_n_i,
  input  logic [DATA_W-1:0] out_word_i,
  input  logic [DATA_W-1:0] ctrl_word_i,
  input  logic [DATA_W-1:0] cal_word_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              busy_o,
  output logic              busy_out_o,
  output logic              done_out_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  logic              active_q;
  rd_src_e           src_q;
  logic              short_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;

  rd_src_e           src_sel;
  logic [DATA_W-1:0] word_sel;
  logic              go, shift_en, last;

  always_comb begin
    if (!sel_i) begin
      src_sel  = SRC_CTRL;
      word_sel = ctrl_word_i;
    end else if (cal_sel_i) begin
      src_sel  = SRC_CAL;
      word_sel = cal_word_i;
    end else begin
      src_sel  = SRC_OUT;
      word_sel = out_word_i;
    end
  end

  // output register is only readable while a word is pending
  assign go       = start_i && !active_q && (src_sel != SRC_OUT || !drdy_n_i);
  assign shift_en = active_q && frame_low_i && sclk_fall_i;
  assign last     = cnt_q == (short_q ? LAST_SHORT : LAST_LONG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      src_q    <= SRC_OUT;
      short_q  <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      src_q    <= src_sel;
      short_q  <= (src_sel == SRC_OUT) && short_i;
      cnt_q    <= '0;
      shreg_q  <= word_sel;
    end else if (shift_en) begin
      if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        shreg_q  <= {shreg_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdata_o    = shreg_q[DATA_W-1];
  assign sdata_oe_o = active_q && frame_low_i;
  assign busy_o     = active_q;
  assign busy_out_o = active_q && (src_q == SRC_OUT);
  assign done_out_o = shift_en && last && (src_q == SRC_OUT);
endmodule

// File: rtl/esp_wr_path.sv
`timescale 1ns/1ps
module esp_wr_path #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_low_i,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q, word_q, next_sh;
  logic              done_q;

  assign next_sh = {shreg_q[DATA_W-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_low_i && sclk_rise_i) begin
        shreg_q <= next_sh;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          word_q <= next_sh;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;
endmodule

// File: rtl/ext_serial_port.sv
`timescale 1ns/1ps
module ext_serial_port
  import esp_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_BIT   = 0,
  parameter int CALSEL_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              rd_frame_ni,
  input  logic              wr_frame_ni,
  input  logic              reg_sel_i,
  input  logic              sdata_i,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              drdy_no,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cal_o
);
  pins_t pins_raw, pins_s;
  logic  sclk_d_q, rd_n_d_q;
  logic  sclk_rise, sclk_fall, rd_start;

  logic [DATA_W-1:0] out_q, ctrl_q, cal_q, wr_word;
  logic              drdy_n_q, wr_done;
  logic              rd_busy, rd_busy_out, rd_done_out;
  logic              cal_sel;

  assign pins_raw = '{sel: reg_sel_i, sdata: sdata_i, wr_n: wr_frame_ni,
                      rd_n: rd_frame_ni, sclk: sclk_i};

  esp_sync #(
    .W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      rd_n_d_q <= 1'b1;
    end else begin
      sclk_d_q <= pins_s.sclk;
      rd_n_d_q <= pins_s.rd_n;
    end
  end

  assign sclk_rise = pins_s.sclk && !sclk_d_q;
  assign sclk_fall = !pins_s.sclk && sclk_d_q;
  assign rd_start  = !pins_s.rd_n && rd_n_d_q;
  assign cal_sel   = ctrl_q[CALSEL_BIT];

  esp_rd_path #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rd_start),
    .frame_low_i(!pins_s.rd_n),
    .sclk_fall_i(sclk_fall),
    .sel_i      (pins_s.sel),
    .cal_sel_i  (cal_sel),
    .short_i    (ctrl_q[SHORT_BIT]),
    .drdy_n_i   (drdy_n_q),
    .out_word_i (out_q),
    .ctrl_word_i(ctrl_q),
    .cal_word_i (cal_q),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .busy_o     (rd_busy),
    .busy_out_o (rd_busy_out),
    .done_out_o (rd_done_out)
  );

  esp_wr_path #(.DATA_W(DATA_W)) i_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_low_i(!pins_s.wr_n),
    .sclk_rise_i(sclk_rise),
    .sdata_i    (pins_s.sdata),
    .word_o     (wr_word),
    .done_o     (wr_done)
  );

  // output word and data-ready flag; words during an output read are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      drdy_n_q <= 1'b1;
    end else if (rd_done_out) begin
      drdy_n_q <= 1'b1;
    end else if (conv_valid_i && !rd_busy_out) begin
      out_q    <= conv_data_i;
      drdy_n_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cal_q  <= '0;
    end else if (wr_done) begin
      if (pins_s.sel) cal_q  <= wr_word;
      else            ctrl_q <= wr_word;
    end
  end

  assign drdy_no = drdy_n_q;
  assign ctrl_o  = ctrl_q;
  assign cal_o   = cal_q;
endmodule

// File: rtl/esp_chk.sv
`timescale 1ns/1ps
module esp_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_valid_i,
  input logic              drdy_no,
  input logic [DATA_W-1:0] ctrl_o,
  input logic [DATA_W-1:0] cal_o,
  input logic [DATA_W-1:0] out_word_i,
  input logic              rd_start_i,
  input logic              rd_busy_i,
  input logic              rd_busy_out_i,
  input logic              rd_done_out_i,
  input logic              sel_i,
  input logic              cal_sel_i,
  input logic              wr_done_i
);
  AST_LOAD_SETS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_valid_i && !rd_busy_out_i |=> !drdy_no); // R2

  AST_READY_CLEARS_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_no) |-> $past(rd_done_out_i)); // R3

  AST_NO_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i && !rd_busy_i && sel_i && !cal_sel_i && drdy_no |=> !rd_busy_i); // R4

  AST_BUSY_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_busy_i) |-> $past(rd_start_i)); // R5

  AST_DROP_DURING_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_out_i && conv_valid_i |=> $stable(out_word_i)); // R7

  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_done_i |=> $stable(ctrl_o) && $stable(cal_o)); // R9
endmodule

bind ext_serial_port esp_chk #(.DATA_W(DATA_W)) i_esp_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_valid_i (conv_valid_i),
  .drdy_no      (drdy_no),
  .ctrl_o       (ctrl_o),
  .cal_o        (cal_o),
  .out_word_i   (out_q),
  .rd_start_i   (rd_start),
  .rd_busy_i    (rd_busy),
  .rd_busy_out_i(rd_busy_out),
  .rd_done_out_i(rd_done_out),
  .sel_i        (pins_s.sel),
  .cal_sel_i    (cal_sel),
  .wr_done_i    (wr_done)
);

// File: tb/test_ext_serial_port.sv
`timescale 1ns/1ps
module test_ext_serial_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, rfs_n = 1'b1, tfs_n = 1'b1, sel = 1'b0, sdi = 1'b0, cv = 1'b0;
  logic [23:0] cd = '0;
  logic        sdo, oe, drdy_n;
  logic [23:0] ctrl, cal;
  int          total = 0, fails = 0;

  always #4 clk = ~clk;

  ext_serial_port i_ext_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .rd_frame_ni(rfs_n),
    .wr_frame_ni(tfs_n), .reg_sel_i(sel), .sdata_i(sdi), .conv_valid_i(cv),
    .conv_data_i(cd), .sdata_o(sdo), .sdata_oe_o(oe), .drdy_no(drdy_n),
    .ctrl_o(ctrl), .cal_o(cal)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [23:0] w);
    cd = w; cv = 1'b1; wt(1); cv = 1'b0; wt(3);
  endtask

  task automatic rd_bits(input logic a, input int n, output logic [23:0] got,
                         output int bad, output logic oe_end);
    sel = a; wt(2); rfs_n = 1'b0; wt(8);
    got = '0; bad = 0;
    for (int i = 0; i < n; i++) begin
      if (oe !== 1'b1) bad++;
      got = {got[22:0], sdo};
      sclk = 1'b1; wt(6); sclk = 1'b0; wt(6);
    end
    oe_end = oe;
    rfs_n = 1'b1; wt(6);
  endtask

  task automatic full_read(input logic a, input int n, input int split, output logic [23:0] got,
                           output int bad, output logic oe_end);
    logic [23:0] g1, g2;
    int b1, b2;
    logic e1;
    if (split > 0 && split < n) begin
      rd_bits(a, split, g1, b1, e1);
      chk(oe === 1'b0, "R6 paused output disabled", 24'(oe), 24'h0);
      chk(e1 === 1'b1, "R6 enable held mid-word", 24'(e1), 24'h1);
      rd_bits(a, n - split, g2, b2, oe_end);
      got = 24'((g1 << (n - split)) | g2);
      bad = b1 + b2;
    end else begin
      rd_bits(a, n, got, bad, oe_end);
    end
  endtask

  task automatic wr_word(input logic a, input logic [23:0] d, input int split);
    sel = a; wt(2); tfs_n = 1'b0; wt(4);
    for (int i = 0; i < 24; i++) begin
      sdi = d[23-i]; wt(3);
      sclk = 1'b1; wt(6); sclk = 1'b0; wt(3);
      if (split == i + 1) begin
        tfs_n = 1'b1; sdi = ~sdi; wt(4);
        sclk = 1'b1; wt(6); sclk = 1'b0; wt(6);
        tfs_n = 1'b0; wt(4);
      end
    end
    tfs_n = 1'b1; wt(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [23:0] w, a, b, g, g2;
    int bad, bad2;
    logic oe_e, d0;
    wt(3); rst_n = 1'b1; wt(4);
    // R1
    chk(drdy_n === 1'b1, "R1 ready flag", 24'(drdy_n), 24'h1);
    chk(oe === 1'b0, "R1 output enable", 24'(oe), 24'h0);
    chk(ctrl === 24'h0, "R1 control", ctrl, 24'h0);
    chk(cal === 24'h0, "R1 calibration", cal, 24'h0);

    // R3 R6: 24-bit reads split at every position
    for (int k = 0; k < 24; k++) begin
      w = 24'(k * 40503 + 370883);
      push(w);
      chk(drdy_n === 1'b0, "R2 load sets ready", 24'(drdy_n), 24'h0);
      if (k > 0) begin
        rd_bits(1'b1, k, g, bad, oe_e);
        chk(drdy_n === 1'b0, "R3 ready held mid-word", 24'(drdy_n), 24'h0);
        chk(oe === 1'b0, "R6 paused output disabled", 24'(oe), 24'h0);
        rd_bits(1'b1, 24 - k, g2, bad2, oe_e);
        g = 24'((g << (24 - k)) | g2);
        bad += bad2;
      end else begin
        full_read(1'b1, 24, 0, g, bad, oe_e);
      end
      chk(g === w, "R6 split read value", g, w);
      chk(drdy_n === 1'b1, "R3 ready cleared at end", 24'(drdy_n), 24'h1);
      chk(bad == 0, "R5 enable during bits", 24'(bad), 24'h0);
      chk(oe_e === 1'b0, "R5 disabled after last bit", 24'(oe_e), 24'h0);
    end

    // R4: read with nothing pending
    sel = 1'b1; wt(2); rfs_n = 1'b0; wt(8);
    for (int i = 0; i < 4; i++) begin
      chk(oe === 1'b0, "R4 no transfer when not ready", 24'(oe), 24'h0);
      sclk = 1'b1; wt(6); sclk = 1'b0; wt(6);
    end
    rfs_n = 1'b1; wt(6);
    chk(drdy_n === 1'b1, "R4 flag unchanged", 24'(drdy_n), 24'h1);
    w = 24'hC3A561; push(w);
    full_read(1'b1, 24, 0, g, bad, oe_e);
    chk(g === w, "R4 no bits consumed", g, w);

    // R2: newest word wins
    a = 24'h123456; b = 24'hFEDCBA;
    push(a); push(b);
    full_read(1'b1, 24, 0, g, bad, oe_e);
    chk(g === b, "R2 newest word read", g, b);

    // R7: word arriving mid-read is dropped
    push(a);
    rd_bits(1'b1, 10, g, bad, oe_e);
    push(b);
    chk(drdy_n === 1'b0, "R7 flag low during read", 24'(drdy_n), 24'h0);
    rd_bits(1'b1, 14, g2, bad2, oe_e);
    g = 24'((g << 14) | g2);
    chk(g === a, "R7 read keeps old word", g, a);
    chk(drdy_n === 1'b1, "R7 dropped word not flagged", 24'(drdy_n), 24'h1);

    // R9: control write, 16-bit mode
    d0 = drdy_n;
    wr_word(1'b0, 24'h3C5A01, 7);
    chk(ctrl === 24'h3C5A01, "R9 control write", ctrl, 24'h3C5A01);
    chk(drdy_n === d0, "R9 write leaves flag", 24'(drdy_n), 24'(d0));

    // R3: 16-bit reads
    for (int k = 0; k < 8; k++) begin
      w = 24'(k * 611953 + 9001);
      push(w);
      full_read(1'b1, 16, 2 * k + 1, g, bad, oe_e);
      chk(g[15:0] === w[23:8], "R3 short read upper bits", {8'h0, g[15:0]}, {8'h0, w[23:8]});
      chk(drdy_n === 1'b1, "R3 ready cleared at bit 16", 24'(drdy_n), 24'h1);
      chk(oe_e === 1'b0, "R5 disabled after short word", 24'(oe_e), 24'h0);
    end

    // R8: control and calibration reads
    wr_word(1'b1, 24'h81F00D, 0);
    chk(cal === 24'h81F00D, "R9 calibration write", cal, 24'h81F00D);
    full_read(1'b0, 24, 5, g, bad, oe_e);
    chk(g === 24'h3C5A01, "R8 control read with flag high", g, 24'h3C5A01);
    chk(drdy_n === 1'b1, "R8 control read keeps flag", 24'(drdy_n), 24'h1);
    wr_word(1'b0, 24'h000003, 12);
    push(24'h0F0F0F);
    full_read(1'b1, 24, 9, g, bad, oe_e);
    chk(g === 24'h81F00D, "R8 calibration read 24 bits", g, 24'h81F00D);
    chk(drdy_n === 1'b0, "R8 calibration read keeps flag", 24'(drdy_n), 24'h0);

    // R9: walking one into calibration, paused at each position
    for (int p = 0; p < 24; p++) begin
      w = 24'(1) << p;
      wr_word(1'b1, w, p);
      chk(cal === w, "R9 walking write", cal, w);
    end
    chk(drdy_n === 1'b0, "R9 writes leave flag", 24'(drdy_n), 24'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule